// File: doc/BRIEF.md
# Dual-Clock Eighteen-Bit Queue with Occupancy Flags

This block is a first-in first-out buffer for 18-bit words whose write side and read side each run on their own clock. The two clocks may be unrelated, or the same net may drive both. The read and write positions cross between the domains as Gray codes through two-stage synchronizers. Every status flag is a register owned by exactly one domain. Empty and the low-water flag belong to the read clock. Full, the high-water flag and the half-level flag belong to the write clock. Together the five flags describe one of five fill states: empty, nearly empty, past half, nearly full and full.

Software-free configuration is done at the pins. The low-water and high-water distances can be reloaded from value inputs with one-cycle load strobes, and both default to 7 words after reset. A rewind input sends the read position back to the first word stored since reset, so a short message can be replayed. An output gate forces the data output to zero.

Several identical slices can be chained into one deeper queue. Each slice then passes a write token and a read token around a ring. In that ring mode the half-level output carries the outgoing write token instead of its normal meaning.

Top module: `fifo18_dc`

## Requirements
- R1: After reset, empty and almost_empty are 1; full, almost_full and hf_wx are 0; dout is 0. Both offset registers hold 7.
- R2: Words come out in the order they were written, all 18 bits intact. A read accepted at a rclk edge presents its word on dout just after that edge.
- R3: full rises at the same wclk edge as the write that brings the occupancy to the depth. A write attempted while full is dropped and does not move the write position.
- R4: empty rises at the same rclk edge as the read that takes the last word. A read attempted while empty is dropped: dout holds its value and the read position does not move.
- R5: A write into an empty queue clears empty at the third rclk edge after the write edge. A read from a full queue clears full at the third wclk edge after the read edge.
- R6: almost_empty is a read-domain register that is 1 when the occupancy seen by the read side is at most the low-water offset.
- R7: almost_full is a write-domain register that is 1 when the occupancy seen by the write side is at least the depth minus the high-water offset.
- R8: In standalone mode (xp_mode = 0), hf_wx is a write-domain register that is 1 when the occupancy is above half the depth.
- R9: ae_ld high at a rclk edge loads ae_val as the low-water offset. af_ld high at a wclk edge loads af_val as the high-water offset. The flags use the new offsets from the next edge on.
- R10: rt high at a rclk edge sets the read position to address 0, where the first word after reset was stored. Any read enable in that cycle is ignored, and the write side keeps its position. Replay is valid while at most the depth of words have been written since reset.
- R11: While oe is 0, dout is 0. While oe is 1, dout shows the held read word.
- R12: With xp_mode = 1, a slice accepts writes or reads only while it holds the matching token. first_load = 1 gives a slice both tokens at reset. A write to the slice's last address drives hf_wx high during that cycle and hands the write token to the slice whose wx_in it feeds. A read from the last address does the same on rx_out.
- R13: With xp_mode = 1, a slice drives dout only if it made the most recent read of the ring. A slice's dout is 0 from the first read made elsewhere until its own next read.
- R14: A read and a write in the same cycle are both carried out, and the order of words is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, held for several edges of both clocks |
| wen | input | 1 | Write enable, sampled on wclk |
| din | input | 18 | Write data |
| ren | input | 1 | Read enable, sampled on rclk |
| oe | input | 1 | Output gate for dout |
| rt | input | 1 | Rewind the read position to address 0 (rclk) |
| dout | output | 18 | Read data |
| empty | output | 1 | No words stored (rclk domain) |
| almost_empty | output | 1 | Occupancy at or below the low-water offset (rclk domain) |
| hf_wx | output | 1 | More than half full in standalone mode; outgoing write token in ring mode |
| almost_full | output | 1 | Occupancy at or above depth minus the high-water offset (wclk domain) |
| full | output | 1 | Every location used (wclk domain) |
| ae_ld | input | 1 | Load strobe for the low-water offset (rclk) |
| ae_val | input | AW+1 | New low-water offset |
| af_ld | input | 1 | Load strobe for the high-water offset (wclk) |
| af_val | input | AW+1 | New high-water offset |
| xp_mode | input | 1 | 1 selects ring (depth-chaining) mode |
| first_load | input | 1 | 1 marks the slice that holds both tokens after reset |
| wx_in | input | 1 | Incoming write token from the previous slice |
| rx_in | input | 1 | Incoming read token from the previous slice |
| rx_out | output | 1 | Outgoing read token to the next slice |

## Verification
Flags owned by the domain that made the change are due at that same edge. Read data is due just after the read edge. Cross-domain changes of empty and full are due at the third edge of the observing clock, so the bench samples the edge before and the edge on which the change falls. For the settled flag sweeps, which step the occupancy through every value from 0 to the depth with two offset settings, the bench idles four cycles after each operation before it compares the flags against the occupancy it computes itself. All sampling is done on the falling edge, away from the edge that moves the design. The token outputs are combinational, so the bench samples them one nanosecond after driving the enables.

// File: rtl/fifo18_pkg.sv
`timescale 1ns/1ps
package fifo18_pkg;
  localparam int DATA_W = 18;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/fifo18_xsync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for a Gray-coded position, followed by Gray to binary.
module fifo18_xsync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage1, stage2;
  logic [W-1:0] conv;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  always_comb begin
    conv[W-1] = stage2[W-1];
    for (int i = W - 2; i >= 0; i--) conv[i] = conv[i+1] ^ stage2[i];
  end

  assign bin_out = conv;
endmodule

// File: rtl/fifo18_ram.sv
`timescale 1ns/1ps
// Simple dual-port storage: write on one clock, registered read on the other.
module fifo18_ram
  import fifo18_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic          rclk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  localparam int DEPTH = 1 << AW;

  word_t store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rst) rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/fifo18_wside.sv
`timescale 1ns/1ps
// Write-side position, write-domain flags and write token.
module fifo18_wside #(
  parameter int AW      = 6,
  parameter int OFS_DEF = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wen,
  input  logic          xp,
  input  logic          first_load,
  input  logic          tok_in,
  input  logic          ofs_ld,
  input  logic [AW:0]   ofs_val,
  input  logic [AW:0]   rq_bin,
  output logic          wr_ok,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          almost_full,
  output logic          half_full,
  output logic          tok_pass
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0]   HALF_CNT = (AW+1)'(DEPTH / 2);
  localparam logic [AW:0]   OFS_INIT = (AW+1)'(OFS_DEF);
  localparam logic [AW+1:0] DEPTH_X  = (AW+2)'(DEPTH);

  logic [AW:0]   wbin, wbin_n, cnt_n, ofs;
  logic [AW+1:0] reach;
  logic          tok;

  assign wr_ok    = wen && !full && (!xp || tok);
  assign wbin_n   = wbin + (AW+1)'(wr_ok);
  assign cnt_n    = wbin_n - rq_bin;
  assign reach    = {1'b0, cnt_n} + {1'b0, ofs};
  assign tok_pass = xp && wr_ok && (&wbin[AW-1:0]);
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin        <= '0;
      wgray       <= '0;
      full        <= 1'b0;
      almost_full <= 1'b0;
      half_full   <= 1'b0;
      ofs         <= OFS_INIT;
      tok         <= first_load;
    end else begin
      wbin        <= wbin_n;
      wgray       <= wbin_n ^ (wbin_n >> 1);
      full        <= (cnt_n == FULL_CNT);
      almost_full <= (reach >= DEPTH_X);
      half_full   <= (cnt_n > HALF_CNT);
      if (ofs_ld) ofs <= ofs_val;
      if (tok_in) tok <= 1'b1;
      else if (tok_pass) tok <= 1'b0;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full && wen) |=> (wbin == $past(wbin)));

  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ((wbin - rq_bin) <= FULL_CNT));

  // R7
  af_covers_full_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> almost_full);

  // R12
  wtok_release_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_pass && !tok_in) |=> !tok);
endmodule

// File: rtl/fifo18_rside.sv
`timescale 1ns/1ps
// Read-side position, read-domain flags, rewind and read token.
module fifo18_rside #(
  parameter int AW      = 6,
  parameter int OFS_DEF = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren,
  input  logic          rt,
  input  logic          xp,
  input  logic          first_load,
  input  logic          tok_in,
  input  logic          ofs_ld,
  input  logic [AW:0]   ofs_val,
  input  logic [AW:0]   wq_bin,
  output logic          rd_ok,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          empty,
  output logic          almost_empty,
  output logic          tok_pass,
  output logic          drive
);
  localparam logic [AW:0] OFS_INIT = (AW+1)'(OFS_DEF);

  logic [AW:0] rbin, rbin_n, cnt_n, ofs;
  logic        tok;

  assign rd_ok    = ren && !rt && !empty && (!xp || tok);
  assign rbin_n   = rt ? '0 : (rbin + (AW+1)'(rd_ok));
  assign cnt_n    = wq_bin - rbin_n;
  assign tok_pass = xp && rd_ok && (&rbin[AW-1:0]);
  assign raddr    = rbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin         <= '0;
      rgray        <= '0;
      empty        <= 1'b1;
      almost_empty <= 1'b1;
      ofs          <= OFS_INIT;
      tok          <= first_load;
      drive        <= 1'b0;
    end else begin
      rbin         <= rbin_n;
      rgray        <= rbin_n ^ (rbin_n >> 1);
      empty        <= (cnt_n == '0);
      almost_empty <= (cnt_n <= ofs);
      if (ofs_ld) ofs <= ofs_val;
      if (tok_in) tok <= 1'b1;
      else if (tok_pass) tok <= 1'b0;
      if (rd_ok) drive <= 1'b1;
      else if (ren && !tok) drive <= 1'b0;
    end
  end

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && ren && !rt) |=> (rbin == $past(rbin)));

  // R6
  ae_covers_empty_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> almost_empty);

  // R10
  rewind_chk: assert property (@(posedge clk) disable iff (rst)
    rt |=> (rbin == '0));

  // R12
  rtok_release_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_pass && !tok_in) |=> !tok);
endmodule

// File: rtl/fifo18_dc.sv
`timescale 1ns/1ps
// Dual-clock 18-bit queue with occupancy flags, rewind and ring chaining.
module fifo18_dc
  import fifo18_pkg::*;
#(
  parameter int AW      = 6,
  parameter int OFS_DEF = 7
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst,
  input  logic              wen,
  input  logic [DATA_W-1:0] din,
  input  logic              ren,
  input  logic              oe,
  input  logic              rt,
  output logic [DATA_W-1:0] dout,
  output logic              empty,
  output logic              almost_empty,
  output logic              hf_wx,
  output logic              almost_full,
  output logic              full,
  input  logic              ae_ld,
  input  logic [AW:0]       ae_val,
  input  logic              af_ld,
  input  logic [AW:0]       af_val,
  input  logic              xp_mode,
  input  logic              first_load,
  input  logic              wx_in,
  input  logic              rx_in,
  output logic              rx_out
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray, rq_bin, wq_bin;
  logic [AW-1:0] waddr, raddr;
  logic          wr_ok, rd_ok, w_pass, w_half, r_drive;
  word_t         rdata;

  fifo18_xsync #(.W(PW)) u_r2w (
    .clk(wclk), .rst(rst), .gray_in(rgray), .bin_out(rq_bin)
  );

  fifo18_xsync #(.W(PW)) u_w2r (
    .clk(rclk), .rst(rst), .gray_in(wgray), .bin_out(wq_bin)
  );

  fifo18_wside #(.AW(AW), .OFS_DEF(OFS_DEF)) u_wside (
    .clk(wclk), .rst(rst), .wen(wen), .xp(xp_mode), .first_load(first_load),
    .tok_in(wx_in), .ofs_ld(af_ld), .ofs_val(af_val), .rq_bin(rq_bin),
    .wr_ok(wr_ok), .waddr(waddr), .wgray(wgray), .full(full),
    .almost_full(almost_full), .half_full(w_half), .tok_pass(w_pass)
  );

  fifo18_rside #(.AW(AW), .OFS_DEF(OFS_DEF)) u_rside (
    .clk(rclk), .rst(rst), .ren(ren), .rt(rt), .xp(xp_mode),
    .first_load(first_load), .tok_in(rx_in), .ofs_ld(ae_ld), .ofs_val(ae_val),
    .wq_bin(wq_bin), .rd_ok(rd_ok), .raddr(raddr), .rgray(rgray),
    .empty(empty), .almost_empty(almost_empty), .tok_pass(rx_out),
    .drive(r_drive)
  );

  fifo18_ram #(.AW(AW)) u_ram (
    .wclk(wclk), .we(wr_ok), .waddr(waddr), .wdata(din),
    .rclk(rclk), .rst(rst), .re(rd_ok), .raddr(raddr), .rdata(rdata)
  );

  assign hf_wx = xp_mode ? w_pass : w_half;
  assign dout  = (oe && (!xp_mode || r_drive)) ? rdata : '0;
endmodule

// File: tb/fifo18_dc_tb.sv
`timescale 1ns/1ps
module fifo18_dc_tb;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, wen, ren, oe, rt, ae_ld, af_ld, xp;
  logic [17:0] din;
  logic [AW:0] ae_val, af_val;
  logic [17:0] a_dout, b_dout;
  logic a_empty, a_ae, a_hf, a_af, a_full, a_rx;
  logic b_empty, b_ae, b_hf, b_af, b_full, b_rx;

  fifo18_dc #(.AW(AW)) u_dut (
    .wclk(clk), .rclk(clk), .rst(rst), .wen(wen), .din(din), .ren(ren),
    .oe(oe), .rt(rt), .dout(a_dout), .empty(a_empty), .almost_empty(a_ae),
    .hf_wx(a_hf), .almost_full(a_af), .full(a_full), .ae_ld(ae_ld),
    .ae_val(ae_val), .af_ld(af_ld), .af_val(af_val), .xp_mode(xp),
    .first_load(1'b1), .wx_in(b_hf), .rx_in(b_rx), .rx_out(a_rx)
  );

  fifo18_dc #(.AW(AW)) u_dut2 (
    .wclk(clk), .rclk(clk), .rst(rst), .wen(wen), .din(din), .ren(ren),
    .oe(oe), .rt(rt), .dout(b_dout), .empty(b_empty), .almost_empty(b_ae),
    .hf_wx(b_hf), .almost_full(b_af), .full(b_full), .ae_ld(ae_ld),
    .ae_val(ae_val), .af_ld(af_ld), .af_val(af_val), .xp_mode(xp),
    .first_load(1'b0), .wx_in(a_hf), .rx_in(a_rx), .rx_out(b_rx)
  );

  int n_chk = 0;
  int n_fail = 0;
  int ae_t, af_t;
  logic done = 1'b0;
  logic [17:0] q[$];
  logic [17:0] last;

  function automatic logic [17:0] pat(int i);
    return 18'(i * 2877) ^ 18'h25A5A;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cyc(logic w, logic [17:0] d, logic r);
    wen = w; din = d; ren = r;
    @(negedge clk);
    wen = 1'b0; ren = 1'b0;
  endtask

  task automatic wr(logic [17:0] d);
    cyc(1'b1, d, 1'b0);
    if (q.size() < DEPTH) q.push_back(d);
  endtask

  task automatic rd(string req);
    logic [17:0] e;
    e = last;
    if (q.size() > 0) begin
      e = q.pop_front();
      last = e;
    end
    cyc(1'b0, 18'h0, 1'b1);
    chk(req, 32'(a_dout), 32'(e));
  endtask

  task automatic flags(string tag);
    int c;
    c = q.size();
    chk({tag, " R4 empty"},        32'(a_empty), 32'(c == 0));
    chk({tag, " R6 almost_empty"}, 32'(a_ae),    32'(c <= ae_t));
    chk({tag, " R8 half"},         32'(a_hf),    32'(c > DEPTH / 2));
    chk({tag, " R7 almost_full"},  32'(a_af),    32'(c >= DEPTH - af_t));
    chk({tag, " R3 full"},         32'(a_full),  32'(c == DEPTH));
  endtask

  task automatic do_reset(logic mode);
    rst = 1'b1; wen = 1'b0; ren = 1'b0; rt = 1'b0; oe = 1'b1;
    ae_ld = 1'b0; af_ld = 1'b0; din = '0; xp = mode;
    idle(4);
    rst = 1'b0;
    q.delete();
    last = '0;
    ae_t = 7; af_t = 7;
  endtask

  // Full sweep of occupancy: fill to the depth, overflow try, drain, underflow try.
  task automatic fill_drain(int base, string tag);
    for (int i = 0; i < DEPTH; i++) begin
      wr(pat(base + i));
      chk({tag, " R3 full same edge"}, 32'(a_full), 32'(q.size() == DEPTH));
      chk({tag, " R8 half same edge"}, 32'(a_hf),   32'(q.size() > DEPTH / 2));
      idle(4);
      flags(tag);
    end
    wr(18'h3FFFF);
    idle(4);
    chk({tag, " R3 write while full"}, 32'(a_full), 32'd1);
    for (int i = 0; i < DEPTH; i++) begin
      rd({tag, " R2 order"});
      chk({tag, " R4 empty same edge"}, 32'(a_empty), 32'(q.size() == 0));
      chk({tag, " R6 ae same edge"},    32'(a_ae),    32'(q.size() <= ae_t));
      idle(4);
      flags(tag);
    end
    cyc(1'b0, 18'h0, 1'b1);
    chk({tag, " R4 read while empty holds dout"}, 32'(a_dout), 32'(last));
    wr(pat(base + 99));
    idle(4);
    rd({tag, " R4 read position unmoved"});
    idle(4);
    flags(tag);
  endtask

  initial begin
    rst = 1'b1; wen = 1'b0; ren = 1'b0; rt = 1'b0; oe = 1'b1;
    ae_ld = 1'b0; af_ld = 1'b0; din = '0; xp = 1'b0;
    ae_val = '0; af_val = '0;
    @(negedge clk);
    do_reset(1'b0);

    // R1 reset state
    chk("R1 empty",        32'(a_empty), 32'd1);
    chk("R1 almost_empty", 32'(a_ae),    32'd1);
    chk("R1 full",         32'(a_full),  32'd0);
    chk("R1 almost_full",  32'(a_af),    32'd0);
    chk("R1 hf_wx",        32'(a_hf),    32'd0);
    chk("R1 dout",         32'(a_dout),  32'd0);

    fill_drain(0, "default");

    // R5 crossing latency, write into empty
    wr(pat(200));
    idle(2);
    chk("R5 empty still set at third-minus-one edge", 32'(a_empty), 32'd1);
    idle(1);
    chk("R5 empty clears at third edge", 32'(a_empty), 32'd0);
    for (int i = 1; i < DEPTH; i++) wr(pat(200 + i));
    idle(4);
    chk("R3 full after depth writes", 32'(a_full), 32'd1);
    rd("R2 first out");
    idle(2);
    chk("R5 full still set at third-minus-one edge", 32'(a_full), 32'd1);
    idle(1);
    chk("R5 full clears at third edge", 32'(a_full), 32'd0);
    while (q.size() > 0) rd("R2 drain");
    idle(4);

    // R11 output gate
    oe = 1'b0; #1;
    chk("R11 gated dout", 32'(a_dout), 32'd0);
    oe = 1'b1; #1;
    chk("R11 open dout", 32'(a_dout), 32'(last));
    @(negedge clk);

    // R14 simultaneous read and write
    for (int i = 0; i < 4; i++) wr(pat(300 + i));
    idle(4);
    for (int i = 0; i < 8; i++) begin
      logic [17:0] e;
      e = q.pop_front();
      q.push_back(pat(304 + i));
      cyc(1'b1, pat(304 + i), 1'b1);
      last = e;
      chk("R14 concurrent order", 32'(a_dout), 32'(e));
    end
    while (q.size() > 0) rd("R14 drain");
    idle(4);
    flags("R14 settled");

    // R9 offset reload, then a second sweep with new thresholds
    do_reset(1'b0);
    ae_val = 5'd2; af_val = 5'd3; ae_ld = 1'b1; af_ld = 1'b1;
    @(negedge clk);
    ae_ld = 1'b0; af_ld = 1'b0;
    ae_t = 2; af_t = 3;
    idle(2);
    fill_drain(400, "R9 reloaded");

    // R10 rewind
    do_reset(1'b0);
    for (int i = 0; i < 5; i++) wr(pat(500 + i));
    idle(4);
    for (int i = 0; i < 3; i++) rd("R10 before rewind");
    rt = 1'b1;
    cyc(1'b0, 18'h0, 1'b1);
    rt = 1'b0;
    chk("R10 read ignored during rewind", 32'(a_dout), 32'(pat(502)));
    idle(4);
    q.delete();
    for (int i = 0; i < 5; i++) q.push_back(pat(500 + i));
    flags("R10 after rewind");
    for (int i = 0; i < 5; i++) rd("R10 replay");
    idle(4);
    chk("R10 empty after replay", 32'(a_empty), 32'd1);

    // R12 R13 two-slice ring
    do_reset(1'b1);
    for (int i = 0; i < 24; i++) begin
      wen = 1'b1; din = pat(600 + i);
      #1;
      chk("R12 write token out of first slice", 32'(a_hf), 32'(i == 15));
      chk("R12 write token out of second slice", 32'(b_hf), 32'd0);
      @(negedge clk);
    end
    wen = 1'b0;
    idle(4);
    chk("R12 first slice full", 32'(a_full), 32'd1);
    chk("R12 hf_wx repurposed", 32'(a_hf), 32'd0);
    chk("R12 second slice holds words", 32'(b_empty), 32'd0);
    chk("R12 second slice not full", 32'(b_full), 32'd0);
    for (int i = 0; i < 24; i++) begin
      ren = 1'b1;
      #1;
      chk("R12 read token out", 32'(a_rx), 32'(i == 15));
      @(negedge clk);
      chk("R13 ring order", 32'(a_dout | b_dout), 32'(pat(600 + i)));
      if (i < 16) chk("R13 idle slice silent", 32'(b_dout), 32'd0);
      else        chk("R13 idle slice silent", 32'(a_dout), 32'd0);
    end
    ren = 1'b0;
    idle(4);
    chk("R12 both slices empty", 32'(a_empty & b_empty), 32'd1);

    done = 1'b1;
    summary();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end
endmodule